// File: doc/BRIEF.md
# Flash Write Guard with Ready/Busy Indication

This block is the control front end of a parallel NOR-style flash memory model. It watches the host's active-low chip enable, write enable and output enable, together with a low-supply flag and a deep power-down request. It passes a host write on to the command logic only when the enables form a true write and have held that state for a set number of clock cycles. A low supply masks all writes and forces the command logic back to read mode.

Accepted writes go into a small command sequencer. Two unlock writes, then an operation code, then an operand write start the program or erase engine. While the engine runs, the block pulls its ready/busy line low. It releases the line when the engine reports completion, when an erase is suspended, or when deep power-down is requested. The ready/busy output is a pull-low enable, so several instances can share one wired-AND ready line.

Top module: `flash_wguard`

## Requirements
- R1: `cmd_wr` pulses only for a host cycle with `ce_n`=0, `we_n`=0 and `oe_n`=1. Any other combination (`oe_n`=0, `ce_n`=1 or `we_n`=1) produces no strobe. `cmd_addr`/`cmd_data` carry the bus address and data present while the write qualified.
- R2: After the two-stage synchroniser, the write condition must hold for at least GLITCH_CYC (default 4) consecutive clock cycles before `cmd_wr` fires. Each qualifying low pulse gives exactly one one-cycle strobe, however long it lasts.
- R3: While `low_vdd` is high, `rd_mode_rst` is high, no `cmd_wr` is produced and the sequencer is held in read mode. Writes are accepted again once `low_vdd` clears.
- R4: After reset, `cmd_wr`, `eng_start`, `eng_abort`, `rd_mode_rst` and `ryby_pull` are all 0, and the sequencer is in read mode.
- R5: The start sequence is four accepted writes: (1) address 0x55 with data 0xAA; (2) address 0xAA with data 0x55; (3) data 0xA0 for program or 0x80 for erase; (4) operand write. On the fourth write, `eng_start` pulses once, `eng_erase` shows the operation, `eng_addr`/`eng_data` latch the operand, and `ryby_pull` goes to 1. It returns to 0 in the cycle after `eng_done` is seen.
- R6: `ryby_pull` is a driven output whose value while busy does not depend on `ce_n` or `oe_n`. Writes arriving during an operation, other than suspend/resume codes, do not change it.
- R7: During an erase, a write with data 0xB0 suspends it: `eng_hold`=1 and `ryby_pull`=0. Data 0x30 resumes it. The suspend code has no effect during a program.
- R8: `sleep_req` high releases `ryby_pull` and blocks all writes. Busy is restored when `sleep_req` falls if the operation is still pending.
- R9: A write that breaks the unlock/operation sequence returns the sequencer to read mode. No `eng_start` ever results from a single write or from an incomplete sequence.
- R10: If `low_vdd` rises while an operation is busy or suspended, `eng_abort` pulses once, `ryby_pull` and `eng_hold` drop, and the sequencer returns to read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| ce_n | input | 1 | Host chip enable, active low, asynchronous |
| we_n | input | 1 | Host write enable, active low, asynchronous |
| oe_n | input | 1 | Host output enable, active low, asynchronous |
| low_vdd | input | 1 | Supply-below-lockout flag from comparator, asynchronous |
| sleep_req | input | 1 | Deep power-down request, asynchronous |
| bus_addr | input | AW | Host address |
| bus_data | input | DW | Host write data |
| eng_done | input | 1 | Completion pulse from program/erase engine |
| cmd_wr | output | 1 | Qualified write strobe to command register |
| cmd_addr | output | AW | Address of the qualified write |
| cmd_data | output | DW | Data of the qualified write |
| rd_mode_rst | output | 1 | Forces read mode while supply is low |
| ryby_pull | output | 1 | Pull-low enable of the ready/busy line (1 = busy) |
| eng_start | output | 1 | One-cycle engine start pulse |
| eng_erase | output | 1 | Operation of last start: 1 erase, 0 program |
| eng_addr | output | AW | Operand address for the engine |
| eng_data | output | DW | Operand data for the engine |
| eng_hold | output | 1 | Engine pause (erase suspend or power-down while busy) |
| eng_abort | output | 1 | One-cycle abort pulse on supply loss during an operation |

## Verification
The assertions check several rules on every cycle. A strobe must be preceded by a true write condition, and must come after a synchronised run at least the filter length long. No two strobes may be back to back. A start pulse must follow a strobe and raise busy. Busy must be released one cycle after low supply or completion, and a hold must never coexist with busy. Only the bench's scenarios can show the rest: which enable combinations and pulse widths produce strobes, that a broken unlock sequence leaves the engine idle, that suspend is ignored during a program, and that busy returns after sleep and resume.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

   typedef enum logic [2:0] {
      SQ_READ   = 3'd0,
      SQ_UNL1   = 3'd1,
      SQ_UNL2   = 3'd2,
      SQ_OPND_P = 3'd3,
      SQ_OPND_E = 3'd4,
      SQ_BUSY_P = 3'd5,
      SQ_BUSY_E = 3'd6,
      SQ_SUSP   = 3'd7
   } seq_state_t;

   localparam int unsigned CODE_W = 8;

endpackage

// File: rtl/fwg_sync.sv
module fwg_sync #(
   parameter int unsigned W       = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fwg_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("fwg_sync: W must be at least 1");
      end
   endgenerate

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= {STAGES{RST_VAL[b]}};
         else        sh <= {sh[STAGES-2:0], d[b]};
      end
      assign q[b] = sh[STAGES-1];
   end

endmodule

// File: rtl/fwg_qual.sv
module fwg_qual #(
   parameter int unsigned GLITCH_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_s,
   input  logic we_s,
   input  logic oe_s,
   input  logic inhibit,
   output logic cap,
   output logic wr_stb
);

   localparam int unsigned CW = $clog2(GLITCH_CYC + 1);

   generate
      if (GLITCH_CYC < 1) begin : g_bad_glitch
         $error("fwg_qual: GLITCH_CYC must be at least 1");
      end
   endgenerate

   logic          cond;
   logic [CW-1:0] cnt;
   logic          fired;

   assign cond = ~ce_s & ~we_s & oe_s & ~inhibit;
   assign cap  = cond & ~fired & (cnt == CW'(GLITCH_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         fired  <= 1'b0;
         wr_stb <= 1'b0;
      end else begin
         wr_stb <= 1'b0;
         if (!cond) begin
            cnt   <= '0;
            fired <= 1'b0;
         end else if (!fired) begin
            if (cap) begin
               wr_stb <= 1'b1;
               fired  <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // checker-side run length of the raw enable condition (saturating)
   logic [CW-1:0] run_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              run_len <= '0;
      else if (ce_s | we_s | ~oe_s)            run_len <= '0;
      else if (run_len != CW'(GLITCH_CYC))     run_len <= run_len + 1'b1;
   end

   a_r1_strobe_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> $past(~ce_s & ~we_s & oe_s));

   a_r2_min_width: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> (run_len == CW'(GLITCH_CYC)));

   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   a_r3_no_strobe_inhibited: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> !$past(inhibit));

endmodule

// File: rtl/fwg_seq.sv
module fwg_seq
   import fwg_pkg::*;
#(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 8,
   parameter logic [AW-1:0] UNL_A1   = AW'(8'h55),
   parameter logic [DW-1:0] UNL_D1   = DW'(8'hAA),
   parameter logic [AW-1:0] UNL_A2   = AW'(8'hAA),
   parameter logic [DW-1:0] UNL_D2   = DW'(8'h55),
   parameter logic [DW-1:0] OP_PROG  = DW'(8'hA0),
   parameter logic [DW-1:0] OP_ERASE = DW'(8'h80),
   parameter logic [DW-1:0] OP_SUSP  = DW'(8'hB0),
   parameter logic [DW-1:0] OP_RES   = DW'(8'h30)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [AW-1:0] wa,
   input  logic [DW-1:0] wd,
   input  logic          low,
   input  logic          sleep,
   input  logic          done,
   output logic          eng_start,
   output logic          eng_erase,
   output logic [AW-1:0] eng_addr,
   output logic [DW-1:0] eng_data,
   output logic          eng_abort,
   output logic          eng_hold,
   output logic          busy_pull
);

   seq_state_t st;
   logic       running;
   logic       active;

   assign running   = (st == SQ_BUSY_P) || (st == SQ_BUSY_E);
   assign active    = running || (st == SQ_SUSP);
   assign busy_pull = running & ~sleep;
   assign eng_hold  = (st == SQ_SUSP) || (running && sleep);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= SQ_READ;
         eng_start <= 1'b0;
         eng_abort <= 1'b0;
         eng_erase <= 1'b0;
         eng_addr  <= '0;
         eng_data  <= '0;
      end else begin
         eng_start <= 1'b0;
         eng_abort <= 1'b0;
         if (low) begin
            eng_abort <= active;
            st        <= SQ_READ;
         end else begin
            unique case (st)
               SQ_READ: if (wr) begin
                  st <= (wa == UNL_A1 && wd == UNL_D1) ? SQ_UNL1 : SQ_READ;
               end
               SQ_UNL1: if (wr) begin
                  st <= (wa == UNL_A2 && wd == UNL_D2) ? SQ_UNL2 : SQ_READ;
               end
               SQ_UNL2: if (wr) begin
                  if (wd == OP_PROG)       st <= SQ_OPND_P;
                  else if (wd == OP_ERASE) st <= SQ_OPND_E;
                  else                     st <= SQ_READ;
               end
               SQ_OPND_P, SQ_OPND_E: if (wr) begin
                  eng_start <= 1'b1;
                  eng_erase <= (st == SQ_OPND_E);
                  eng_addr  <= wa;
                  eng_data  <= wd;
                  st        <= (st == SQ_OPND_E) ? SQ_BUSY_E : SQ_BUSY_P;
               end
               SQ_BUSY_P: if (done && !sleep) st <= SQ_READ;
               SQ_BUSY_E: begin
                  if (done && !sleep)          st <= SQ_READ;
                  else if (wr && wd == OP_SUSP) st <= SQ_SUSP;
               end
               SQ_SUSP: if (wr && wd == OP_RES) st <= SQ_BUSY_E;
               default: st <= SQ_READ;
            endcase
         end
      end
   end

   a_r9_start_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> $past(wr));

   a_r5_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_start && !sleep) |-> busy_pull);

   a_r5_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (done && running && !sleep && !low) |=> !busy_pull);

   a_r10_low_releases: assert property (@(posedge clk) disable iff (!rst_n)
      low |=> (!busy_pull && !eng_hold));

   a_r7_hold_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      eng_hold |-> !busy_pull);

   a_r10_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
      eng_abort |=> !eng_abort);

endmodule

// File: rtl/flash_wguard.sv
module flash_wguard #(
   parameter int unsigned AW          = 8,
   parameter int unsigned DW          = 8,
   parameter int unsigned GLITCH_CYC  = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          we_n,
   input  logic          oe_n,
   input  logic          low_vdd,
   input  logic          sleep_req,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_data,
   input  logic          eng_done,
   output logic          cmd_wr,
   output logic [AW-1:0] cmd_addr,
   output logic [DW-1:0] cmd_data,
   output logic          rd_mode_rst,
   output logic          ryby_pull,
   output logic          eng_start,
   output logic          eng_erase,
   output logic [AW-1:0] eng_addr,
   output logic [DW-1:0] eng_data,
   output logic          eng_hold,
   output logic          eng_abort
);

   localparam int unsigned NSYNC = 5;
   localparam logic [NSYNC-1:0] SYNC_RST = 5'b00111;

   generate
      if (DW < fwg_pkg::CODE_W) begin : g_bad_dw
         $error("flash_wguard: DW must hold an 8-bit command code");
      end
      if (AW < 8) begin : g_bad_aw
         $error("flash_wguard: AW must hold an 8-bit unlock address");
      end
   endgenerate

   logic [NSYNC-1:0] raw_in, syn;
   logic ce_s, we_s, oe_s, low_s, sleep_s;
   logic cap;

   assign raw_in = {sleep_req, low_vdd, oe_n, we_n, ce_n};
   assign {sleep_s, low_s, oe_s, we_s, ce_s} = syn;

   fwg_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
   );

   fwg_qual #(.GLITCH_CYC(GLITCH_CYC)) u_qual (
      .clk(clk), .rst_n(rst_n),
      .ce_s(ce_s), .we_s(we_s), .oe_s(oe_s),
      .inhibit(low_s | sleep_s),
      .cap(cap), .wr_stb(cmd_wr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_addr <= '0;
         cmd_data <= '0;
      end else if (cap) begin
         cmd_addr <= bus_addr;
         cmd_data <= bus_data;
      end
   end

   assign rd_mode_rst = low_s;

   fwg_seq #(.AW(AW), .DW(DW)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .wr(cmd_wr), .wa(cmd_addr), .wd(cmd_data),
      .low(low_s), .sleep(sleep_s), .done(eng_done),
      .eng_start(eng_start), .eng_erase(eng_erase),
      .eng_addr(eng_addr), .eng_data(eng_data),
      .eng_abort(eng_abort), .eng_hold(eng_hold),
      .busy_pull(ryby_pull)
   );

   a_r3_no_write_in_lockout: assert property (@(posedge clk) disable iff (!rst_n)
      rd_mode_rst |=> !cmd_wr);

   a_r10_abort_on_low: assert property (@(posedge clk) disable iff (!rst_n)
      eng_abort |-> (rd_mode_rst || $past(rd_mode_rst)));

endmodule

// File: tb/flash_wguard_tb.sv
module flash_wguard_tb;

   localparam int unsigned AW = 8;
   localparam int unsigned DW = 8;
   localparam int unsigned G  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic low_vdd = 1'b0, sleep_req = 1'b0, eng_done = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_data = '0;
   logic cmd_wr, rd_mode_rst, ryby_pull, eng_start, eng_erase, eng_hold, eng_abort;
   logic [AW-1:0] cmd_addr, eng_addr;
   logic [DW-1:0] cmd_data, eng_data;

   always #10 clk = ~clk;

   flash_wguard #(.AW(AW), .DW(DW), .GLITCH_CYC(G)) u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .low_vdd(low_vdd), .sleep_req(sleep_req), .bus_addr(bus_addr),
      .bus_data(bus_data), .eng_done(eng_done), .cmd_wr(cmd_wr),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_mode_rst(rd_mode_rst),
      .ryby_pull(ryby_pull), .eng_start(eng_start), .eng_erase(eng_erase),
      .eng_addr(eng_addr), .eng_data(eng_data), .eng_hold(eng_hold),
      .eng_abort(eng_abort)
   );

   int checks = 0, errors = 0;
   int n_wr = 0, n_start = 0, n_abort = 0;
   bit finished = 1'b0;
   logic [AW-1:0] last_a;
   logic [DW-1:0] last_d;

   always @(negedge clk) begin
      if (rst_n) begin
         if (cmd_wr) begin
            n_wr++;
            last_a = cmd_addr;
            last_d = cmd_data;
         end
         if (eng_start) n_start++;
         if (eng_abort) n_abort++;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_strobes(input bit c, input bit w, input bit o, input int len);
      return (!c && !w && o && len >= G) ? 1 : 0;
   endfunction

   task automatic pulse(input bit c, input bit w, input bit o,
                        input logic [AW-1:0] a, input logic [DW-1:0] d, input int len);
      @(negedge clk);
      bus_addr = a; bus_data = d;
      ce_n = c; we_n = w; oe_n = o;
      repeat (len) @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      pulse(1'b0, 1'b0, 1'b1, a, d, 6);
   endtask

   task automatic start_op(input bit erase, input logic [AW-1:0] a, input logic [DW-1:0] d);
      wr(8'h55, 8'hAA);
      wr(8'hAA, 8'h55);
      wr(8'h00, erase ? 8'h80 : 8'hA0);
      wr(a, d);
   endtask

   task automatic done_pulse();
      @(negedge clk); eng_done = 1'b1;
      @(negedge clk); eng_done = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      int w0, s0, ab0;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R4 reset state
      check("R4 ryby_pull after reset", ryby_pull, 0);
      check("R4 rd_mode_rst after reset", rd_mode_rst, 0);
      check("R4 no strobe after reset", n_wr, 0);
      check("R4 no start after reset", n_start, 0);

      // R1 blocked enable combinations
      w0 = n_wr;
      pulse(1'b0, 1'b0, 1'b0, 8'h12, 8'h34, 6);
      check("R1 oe low blocks", n_wr - w0, 0);
      pulse(1'b1, 1'b0, 1'b1, 8'h12, 8'h34, 6);
      check("R1 ce high blocks", n_wr - w0, 0);
      pulse(1'b0, 1'b1, 1'b1, 8'h12, 8'h34, 6);
      check("R1 we high blocks", n_wr - w0, 0);
      pulse(1'b0, 1'b0, 1'b1, 8'h3C, 8'hC3, 6);
      check("R1 valid write strobes", n_wr - w0, 1);
      check("R1 captured address", last_a, 8'h3C);
      check("R1 captured data", last_d, 8'hC3);

      // R2 glitch filter boundaries
      w0 = n_wr;
      pulse(1'b0, 1'b0, 1'b1, 8'h01, 8'h02, G - 1);
      check("R2 short pulse rejected", n_wr - w0, 0);
      pulse(1'b0, 1'b0, 1'b1, 8'h01, 8'h02, G);
      check("R2 exact width accepted", n_wr - w0, 1);
      pulse(1'b0, 1'b0, 1'b1, 8'h01, 8'h02, 5 * G);
      check("R2 long pulse single strobe", n_wr - w0, 2);

      // R1/R2 constrained random
      for (int i = 0; i < 80; i++) begin
         bit c, w, o;
         int len, e;
         c = ($urandom % 4) == 0;
         w = ($urandom % 4) == 0;
         o = ($urandom % 4) != 0;
         len = 1 + ($urandom % (2 * G));
         e = exp_strobes(c, w, o, len);
         w0 = n_wr;
         pulse(c, w, o, 8'($urandom), 8'h00, len);
         check("R1/R2 random pulse", n_wr - w0, e);
      end
      wr(8'h00, 8'h00);
      check("R9 no start from random traffic", ryby_pull, 0);

      // R9 incomplete / broken sequences
      s0 = n_start;
      wr(8'h55, 8'hAA);
      check("R9 single unlock no start", n_start - s0, 0);
      wr(8'hAA, 8'h55);
      wr(8'h00, 8'h11);
      wr(8'h40, 8'h77);
      check("R9 bad opcode no start", n_start - s0, 0);
      check("R9 bad opcode not busy", ryby_pull, 0);
      wr(8'h55, 8'hAA);
      wr(8'hAB, 8'h55);
      wr(8'h00, 8'hA0);
      wr(8'h40, 8'h77);
      check("R9 bad second unlock no start", n_start - s0, 0);

      // R5 program, R6 enables do not matter, R7 suspend ignored in program
      start_op(1'b0, 8'h9A, 8'h5E);
      check("R5 program start pulse", n_start - s0, 1);
      check("R5 busy after program start", ryby_pull, 1);
      check("R5 program kind", eng_erase, 0);
      check("R5 operand address", eng_addr, 8'h9A);
      check("R5 operand data", eng_data, 8'h5E);
      @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
      repeat (6) @(negedge clk);
      check("R6 busy with ce high oe low", ryby_pull, 1);
      oe_n = 1'b1;
      wr(8'h00, 8'hB0);
      check("R7 suspend ignored in program", ryby_pull, 1);
      check("R7 no hold in program", eng_hold, 0);
      wr(8'h55, 8'hAA);
      check("R6 stray write while busy", ryby_pull, 1);
      done_pulse();
      check("R5 ready after done", ryby_pull, 0);

      // R7 erase suspend / resume, R8 sleep
      start_op(1'b1, 8'h20, 8'h30);
      check("R5 erase kind", eng_erase, 1);
      check("R5 busy after erase start", ryby_pull, 1);
      wr(8'h00, 8'hB0);
      check("R7 suspend releases busy", ryby_pull, 0);
      check("R7 suspend holds engine", eng_hold, 1);
      wr(8'h00, 8'h30);
      check("R7 resume busy again", ryby_pull, 1);
      check("R7 resume clears hold", eng_hold, 0);
      @(negedge clk); sleep_req = 1'b1;
      repeat (4) @(negedge clk);
      check("R8 sleep releases busy", ryby_pull, 0);
      w0 = n_wr;
      wr(8'h00, 8'hB0);
      check("R8 write blocked in sleep", n_wr - w0, 0);
      @(negedge clk); sleep_req = 1'b0;
      repeat (4) @(negedge clk);
      check("R8 busy restored after sleep", ryby_pull, 1);
      done_pulse();
      check("R5 erase done ready", ryby_pull, 0);

      // R10 abort on supply loss, R3 lockout
      start_op(1'b1, 8'h44, 8'h00);
      check("R10 busy before supply loss", ryby_pull, 1);
      ab0 = n_abort;
      @(negedge clk); low_vdd = 1'b1;
      repeat (5) @(negedge clk);
      check("R10 abort pulse", n_abort - ab0, 1);
      check("R10 busy released", ryby_pull, 0);
      check("R3 read-mode reset active", rd_mode_rst, 1);
      w0 = n_wr;
      wr(8'h55, 8'hAA);
      check("R3 write ignored in lockout", n_wr - w0, 0);
      @(negedge clk); low_vdd = 1'b0;
      repeat (4) @(negedge clk);
      check("R3 read-mode reset cleared", rd_mode_rst, 0);
      wr(8'h66, 8'h99);
      check("R3 writes accepted after lockout", n_wr - w0, 1);
      check("R10 no second abort", n_abort - ab0, 1);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule